// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides, one request at a time, whether another thread block may become resident on a streaming multiprocessor. A request carries three numbers: how many threads the block has, how many registers each thread needs, and how many bytes of shared memory the block needs. The controller keeps four running totals of what resident blocks hold: warp slots, block slots, registers and shared-memory bytes. It grants a request only if all four totals stay within their capacities once the new block is added.

Resources are always charged and returned for a whole block. A warp is 32 threads, so a block takes the ceiling of threads/32 warp slots. Its register demand is threads times registers-per-thread. When a block finishes, a one-cycle release carries the same three numbers the block was admitted with. A release is subtracted before the admission check in the same cycle. The live warp count and the fixed warp capacity are driven out, so occupancy (active warps over maximum warps) can be computed outside the block.

A request that can never be admitted is consumed with a reject pulse instead of stalling forever. This covers a register count per thread above 255, zero threads, and a block that would exceed a capacity even on an empty multiprocessor.

Top module: `admit_ctrl`

## Requirements
- R1: After reset the warp, block, register and shared-memory totals are zero, and `max_warps` reads 64.
- R2: A granted block adds ceil(threads/32) to `active_warps`, one to `resident_blocks`, threads×regs-per-thread to `regs_used` and its byte count to `smem_used`. These changes are visible in the cycle after the grant.
- R3: A legal request is not granted (`req_ready` low) while the active warps plus its warps would exceed 64.
- R4: A legal request is not granted while 32 blocks are resident, however few warps they use.
- R5: A legal request is not granted while the register total plus threads×regs-per-thread would exceed 65536. With 256-thread blocks at 34 registers per thread, exactly 7 blocks are admitted.
- R6: A legal request is not granted while the shared-memory total plus its bytes would exceed 65536.
- R7: A request is illegal if regs-per-thread is above 255, threads is zero, or it alone exceeds the warp, register or shared-memory capacity. An illegal request raises `req_ready` and pulses `req_reject` while valid, and it leaves every total unchanged.
- R8: A release subtracts the released block's amounts from every total in the next cycle. A release in the same cycle as a request is applied before that request is checked, so a request that fits only after the release is granted.
- R9: `req_grant` is high only when `req_valid` is high and the request is legal and fits. `req_grant` and `req_reject` are never high together, and `req_ready` equals illegal-or-fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present |
| req_threads | input | 11 | Threads in the requested block |
| req_rpt | input | 9 | Registers per thread of the request |
| req_smem | input | 17 | Shared-memory bytes of the request |
| req_ready | output | 1 | Request would be consumed this cycle (fits or illegal) |
| req_grant | output | 1 | Request admitted this cycle |
| req_reject | output | 1 | Illegal request consumed and dropped this cycle |
| rel_valid | input | 1 | One resident block finishes this cycle |
| rel_threads | input | 11 | Threads of the finishing block |
| rel_rpt | input | 9 | Registers per thread of the finishing block |
| rel_smem | input | 17 | Shared-memory bytes of the finishing block |
| active_warps | output | 7 | Warp slots in use |
| max_warps | output | 7 | Warp capacity, for occupancy |
| resident_blocks | output | 6 | Blocks resident |
| regs_used | output | 17 | Registers allocated |
| smem_used | output | 17 | Shared-memory bytes allocated |

## Verification
A release and an admission check can land in the same cycle. The controller must judge the request against the totals after the release, and it must apply both updates to the stored totals. This is provoked on purpose once the register limit has been reached with seven 256-thread blocks: one block is released in the same cycle as an eighth identical request, which must be granted. The random phase then mixes releases of randomly chosen resident blocks with requests in about a third of all cycles. In every cycle the bench compares ready, grant, reject and the four totals against a model that subtracts the release first.

// File: rtl/admit_pkg.sv
package admit_pkg;

    localparam int NRES     = 3;
    localparam int RES_WARP = 0;
    localparam int RES_REG  = 1;
    localparam int RES_SMEM = 2;

    // per-resource amounts of one block or of a running total
    typedef logic [NRES-1:0][31:0] demand_t;

    function automatic logic [31:0] sat_sub(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : 32'd0;
    endfunction

endpackage

// File: rtl/admit_demand.sv
module admit_demand
    import admit_pkg::*;
#(
    parameter int WARP_SIZE = 32,
    parameter int THR_W     = 11,
    parameter int RPT_W     = 9,
    parameter int SW        = 17
) (
    input  logic [THR_W-1:0] threads,
    input  logic [RPT_W-1:0] rpt,
    input  logic [SW-1:0]    smem,
    output demand_t          dem
);

    localparam logic [31:0] WS      = 32'(WARP_SIZE);
    localparam logic [31:0] WS_M1   = 32'(WARP_SIZE - 1);

    always_comb begin
        dem           = '0;
        dem[RES_WARP] = (32'(threads) + WS_M1) / WS;
        dem[RES_REG]  = 32'(threads) * 32'(rpt);
        dem[RES_SMEM] = 32'(smem);
    end

endmodule

// File: rtl/admit_fit.sv
module admit_fit
    import admit_pkg::*;
#(
    parameter int MAX_WARPS  = 64,
    parameter int MAX_BLOCKS = 32,
    parameter int RF_REGS    = 65536,
    parameter int SMEM_BYTES = 65536
) (
    input  demand_t     base,
    input  logic [31:0] base_blocks,
    input  demand_t     ask,
    output logic        fits,
    output logic        never_fits
);

    localparam demand_t CAPS = {32'(SMEM_BYTES), 32'(RF_REGS), 32'(MAX_WARPS)};

    logic [NRES-1:0] room;
    logic [NRES-1:0] huge;

    for (genvar i = 0; i < NRES; i++) begin : g_res
        assign room[i] = ({1'b0, base[i]} + {1'b0, ask[i]}) <= {1'b0, CAPS[i]};
        assign huge[i] = ask[i] > CAPS[i];
    end

    assign fits       = (&room) && (base_blocks < 32'(MAX_BLOCKS));
    assign never_fits = |huge;

endmodule

// File: rtl/admit_ctrl.sv
module admit_ctrl
    import admit_pkg::*;
#(
    parameter int WARP_SIZE  = 32,
    parameter int MAX_WARPS  = 64,
    parameter int MAX_BLOCKS = 32,
    parameter int RF_REGS    = 65536,
    parameter int MAX_RPT    = 255,
    parameter int SMEM_BYTES = 65536,
    parameter int THR_W      = 11,
    parameter int RPT_W      = 9,
    localparam int WW = $clog2(MAX_WARPS + 1),
    localparam int BW = $clog2(MAX_BLOCKS + 1),
    localparam int RW = $clog2(RF_REGS + 1),
    localparam int SW = $clog2(SMEM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [THR_W-1:0] req_threads,
    input  logic [RPT_W-1:0] req_rpt,
    input  logic [SW-1:0]    req_smem,
    output logic             req_ready,
    output logic             req_grant,
    output logic             req_reject,
    input  logic             rel_valid,
    input  logic [THR_W-1:0] rel_threads,
    input  logic [RPT_W-1:0] rel_rpt,
    input  logic [SW-1:0]    rel_smem,
    output logic [WW-1:0]    active_warps,
    output logic [WW-1:0]    max_warps,
    output logic [BW-1:0]    resident_blocks,
    output logic [RW-1:0]    regs_used,
    output logic [SW-1:0]    smem_used
);

    typedef struct packed {
        logic [WW-1:0] warps;
        logic [BW-1:0] blocks;
        logic [RW-1:0] regs;
        logic [SW-1:0] smem;
    } totals_t;

    totals_t st_d, st_q;

    demand_t     req_dem, rel_dem, rel_amt, base_dem, add_dem;
    logic [31:0] base_blocks;
    logic        fits, never_fits, illegal;
    logic [31:0] sum_w, sum_r, sum_s, sum_b;

    admit_demand #(
        .WARP_SIZE(WARP_SIZE), .THR_W(THR_W), .RPT_W(RPT_W), .SW(SW)
    ) u_req_dem (
        .threads(req_threads), .rpt(req_rpt), .smem(req_smem), .dem(req_dem)
    );

    admit_demand #(
        .WARP_SIZE(WARP_SIZE), .THR_W(THR_W), .RPT_W(RPT_W), .SW(SW)
    ) u_rel_dem (
        .threads(rel_threads), .rpt(rel_rpt), .smem(rel_smem), .dem(rel_dem)
    );

    // release stage: totals seen by the admission check
    always_comb begin
        rel_amt            = rel_valid ? rel_dem : '0;
        base_dem           = '0;
        base_dem[RES_WARP] = sat_sub(32'(st_q.warps), rel_amt[RES_WARP]);
        base_dem[RES_REG]  = sat_sub(32'(st_q.regs),  rel_amt[RES_REG]);
        base_dem[RES_SMEM] = sat_sub(32'(st_q.smem),  rel_amt[RES_SMEM]);
        base_blocks        = sat_sub(32'(st_q.blocks), {31'd0, rel_valid});
    end

    admit_fit #(
        .MAX_WARPS(MAX_WARPS), .MAX_BLOCKS(MAX_BLOCKS),
        .RF_REGS(RF_REGS), .SMEM_BYTES(SMEM_BYTES)
    ) u_fit (
        .base(base_dem), .base_blocks(base_blocks), .ask(req_dem),
        .fits(fits), .never_fits(never_fits)
    );

    // decision and next totals
    always_comb begin
        illegal    = (32'(req_rpt) > 32'(MAX_RPT)) || (req_threads == '0) || never_fits;
        req_ready  = illegal || fits;
        req_grant  = req_valid && fits && !illegal;
        req_reject = req_valid && illegal;

        add_dem = req_grant ? req_dem : '0;
        sum_w   = base_dem[RES_WARP] + add_dem[RES_WARP];
        sum_r   = base_dem[RES_REG]  + add_dem[RES_REG];
        sum_s   = base_dem[RES_SMEM] + add_dem[RES_SMEM];
        sum_b   = base_blocks + {31'd0, req_grant};

        st_d        = st_q;
        st_d.warps  = sum_w[WW-1:0];
        st_d.regs   = sum_r[RW-1:0];
        st_d.smem   = sum_s[SW-1:0];
        st_d.blocks = sum_b[BW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_warps    = st_q.warps;
    assign max_warps       = WW'(MAX_WARPS);
    assign resident_blocks = st_q.blocks;
    assign regs_used       = st_q.regs;
    assign smem_used       = st_q.smem;

endmodule

// File: rtl/admit_ctrl_chk.sv
module admit_ctrl_chk #(
    parameter int MAX_WARPS  = 64,
    parameter int MAX_BLOCKS = 32,
    parameter int RF_REGS    = 65536,
    parameter int SMEM_BYTES = 65536,
    parameter int WW = 7,
    parameter int BW = 6,
    parameter int RW = 17,
    parameter int SW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_grant,
    input logic          req_reject,
    input logic          rel_valid,
    input logic [WW-1:0] active_warps,
    input logic [BW-1:0] resident_blocks,
    input logic [RW-1:0] regs_used,
    input logic [SW-1:0] smem_used
);

    // R9
    grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant && req_reject));

    // R9
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant || req_reject) |-> req_valid);

    // R3
    warp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(active_warps) <= 32'(MAX_WARPS));

    // R4
    block_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(resident_blocks) <= 32'(MAX_BLOCKS));

    // R5
    reg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(regs_used) <= 32'(RF_REGS));

    // R6
    smem_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(smem_used) <= 32'(SMEM_BYTES));

    // R7
    reject_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_reject && !rel_valid) |=> ($stable(active_warps) && $stable(resident_blocks)
                                        && $stable(regs_used) && $stable(smem_used)));

    // R2
    grant_adds_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && !rel_valid) |=> (resident_blocks == $past(resident_blocks) + 1'b1));

    // R8
    release_drops_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !req_grant && resident_blocks != '0)
            |=> (resident_blocks == $past(resident_blocks) - 1'b1));

endmodule

bind admit_ctrl admit_ctrl_chk #(
    .MAX_WARPS(MAX_WARPS), .MAX_BLOCKS(MAX_BLOCKS),
    .RF_REGS(RF_REGS), .SMEM_BYTES(SMEM_BYTES),
    .WW(WW), .BW(BW), .RW(RW), .SW(SW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
    .req_reject(req_reject), .rel_valid(rel_valid), .active_warps(active_warps),
    .resident_blocks(resident_blocks), .regs_used(regs_used), .smem_used(smem_used)
);

// File: tb/sim_admit_ctrl.sv
module sim_admit_ctrl;

    localparam int THR_W = 11;
    localparam int RPT_W = 9;
    localparam int SW    = 17;
    localparam int WW    = 7;
    localparam int BW    = 6;
    localparam int RW    = 17;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             req_valid, req_ready, req_grant, req_reject, rel_valid;
    logic [THR_W-1:0] req_threads, rel_threads;
    logic [RPT_W-1:0] req_rpt, rel_rpt;
    logic [SW-1:0]    req_smem, rel_smem;
    logic [WW-1:0]    active_warps, max_warps;
    logic [BW-1:0]    resident_blocks;
    logic [RW-1:0]    regs_used;
    logic [SW-1:0]    smem_used;

    admit_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_threads(req_threads), .req_rpt(req_rpt), .req_smem(req_smem),
        .req_ready(req_ready), .req_grant(req_grant), .req_reject(req_reject),
        .rel_valid(rel_valid), .rel_threads(rel_threads), .rel_rpt(rel_rpt), .rel_smem(rel_smem),
        .active_warps(active_warps), .max_warps(max_warps), .resident_blocks(resident_blocks),
        .regs_used(regs_used), .smem_used(smem_used)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model of the totals and of the resident blocks
    int m_w = 0, m_b = 0, m_r = 0, m_s = 0;
    int lt [64];
    int lr [64];
    int ls [64];
    int cnt = 0;
    string tag = "R9";
    bit last_grant, last_reject;

    function automatic int wcnt(int t);
        return (t + 31) / 32;
    endfunction

    function automatic bit is_illegal(int t, int rpt, int s);
        return (rpt > 255) || (t == 0) || (wcnt(t) > 64) || (rpt * t > 65536) || (s > 65536);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_totals(string req);
        chk({req, " warps"},  int'(active_warps),    m_w);
        chk({req, " blocks"}, int'(resident_blocks), m_b);
        chk({req, " regs"},   int'(regs_used),       m_r);
        chk({req, " smem"},   int'(smem_used),       m_s);
    endtask

    task automatic step(bit v, int t, int rpt, int s, bit rv, int ri);
        int rt, rr, rs, bw, bb, br, bs;
        bit ill, fit, eg, er;
        @(negedge clk);
        rt = 0; rr = 0; rs = 0;
        if (rv) begin
            rt = lt[ri]; rr = lr[ri]; rs = ls[ri];
        end
        req_valid   = v;
        req_threads = THR_W'(t);
        req_rpt     = RPT_W'(rpt);
        req_smem    = SW'(s);
        rel_valid   = rv;
        rel_threads = THR_W'(rt);
        rel_rpt     = RPT_W'(rr);
        rel_smem    = SW'(rs);
        #1;
        // totals reflect every earlier edge (R2, R8)
        check_totals("R2/R8");
        bw = m_w - (rv ? wcnt(rt) : 0);
        bb = m_b - (rv ? 1 : 0);
        br = m_r - (rv ? rr * rt : 0);
        bs = m_s - (rv ? rs : 0);
        ill = is_illegal(t, rpt, s);
        fit = (bw + wcnt(t) <= 64) && (bb < 32) && (br + rpt * t <= 65536) && (bs + s <= 65536);
        eg  = v && fit && !ill;
        er  = v && ill;
        chk({tag, " R9 ready"},  int'(req_ready),  int'(ill || fit));
        chk({tag, " R9 grant"},  int'(req_grant),  int'(eg));
        chk({tag, " R7 reject"}, int'(req_reject), int'(er));
        last_grant  = req_grant;
        last_reject = req_reject;
        m_w = bw; m_b = bb; m_r = br; m_s = bs;
        if (rv) begin
            lt[ri] = lt[cnt-1]; lr[ri] = lr[cnt-1]; ls[ri] = ls[cnt-1];
            cnt--;
        end
        if (eg) begin
            lt[cnt] = t; lr[cnt] = rpt; ls[cnt] = s;
            cnt++;
            m_w += wcnt(t); m_b += 1; m_r += rpt * t; m_s += s;
        end
    endtask

    task automatic drain();
        while (cnt > 0) step(1'b0, 0, 0, 0, 1'b1, cnt - 1);
        step(1'b0, 0, 0, 0, 1'b0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24680));
        rst_n = 1'b0;
        req_valid = 1'b0; req_threads = '0; req_rpt = '0; req_smem = '0;
        rel_valid = 1'b0; rel_threads = '0; rel_rpt = '0; rel_smem = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_totals("R1");
        chk("R1 max_warps", int'(max_warps), 64);

        // R5: 34 regs x 256 threads admits exactly 7
        tag = "R5";
        for (int i = 0; i < 8; i++) step(1'b1, 256, 34, 0, 1'b0, 0);
        chk("R5 admitted blocks", cnt, 7);
        chk("R5 eighth stalls", int'(last_grant), 0);

        // R8: release and request in the same cycle
        tag = "R8";
        step(1'b1, 256, 34, 0, 1'b1, 0);
        chk("R8 same-cycle grant", int'(last_grant), 1);
        step(1'b0, 0, 0, 0, 1'b0, 0);
        chk("R8 count after swap", int'(resident_blocks), 7);
        drain();

        // R3: warp limit with 16-warp blocks
        tag = "R3";
        for (int i = 0; i < 5; i++) step(1'b1, 512, 1, 0, 1'b0, 0);
        chk("R3 admitted blocks", cnt, 4);
        chk("R3 fifth stalls", int'(last_grant), 0);
        drain();

        // R4: block-slot limit with 1-warp blocks
        tag = "R4";
        for (int i = 0; i < 33; i++) step(1'b1, 32, 1, 0, 1'b0, 0);
        chk("R4 admitted blocks", cnt, 32);
        chk("R4 33rd stalls", int'(last_grant), 0);
        drain();

        // R6: shared-memory limit
        tag = "R6";
        for (int i = 0; i < 4; i++) step(1'b1, 64, 1, 20000, 1'b0, 0);
        chk("R6 admitted blocks", cnt, 3);
        chk("R6 fourth stalls", int'(last_grant), 0);

        // R7: illegal requests are dropped, totals untouched (checked next step)
        tag = "R7";
        step(1'b1, 64, 300, 0, 1'b0, 0);
        chk("R7 rpt over 255", int'(last_reject), 1);
        step(1'b1, 0, 8, 0, 1'b0, 0);
        chk("R7 zero threads", int'(last_reject), 1);
        step(1'b1, 1024, 100, 0, 1'b0, 0);
        chk("R7 regs never fit", int'(last_reject), 1);
        step(1'b1, 32, 1, 70000, 1'b0, 0);
        chk("R7 smem never fits", int'(last_reject), 1);
        step(1'b0, 0, 0, 0, 1'b0, 0);
        chk("R7 blocks unchanged", int'(resident_blocks), 3);
        drain();

        // random mix of requests and releases
        tag = "RND R2 R3 R4 R5 R6 R8";
        for (int i = 0; i < 4000; i++) begin
            bit v, rv;
            int t, rpt, s, ri;
            v   = ($urandom % 10) < 7;
            t   = (($urandom % 16) == 0) ? 0 : 1 + ($urandom % 700);
            rpt = (($urandom % 20) == 0) ? 256 + ($urandom % 100) : ($urandom % 72);
            s   = $urandom % 30000;
            rv  = (cnt > 0) && (($urandom % 10) < 3);
            ri  = (cnt > 0) ? int'($urandom % cnt) : 0;
            step(v, t, rpt, s, rv, ri);
        end
        drain();
        check_totals("R8 drained");
        finish_run();
    end

endmodule